// File: doc/BRIEF.md
# Load/Store Address Generator

This unit forms the memory address for a load or store instruction and, when the addressing form calls for it, the new value to be written back into the base register. Each request supplies a base register value, an index register value, a 12-bit immediate, a 2-bit shift amount, an offset-source code, a direction bit (add or subtract) and an indexing-mode code. The unit takes the offset from the selected source and applies it to the base. It then chooses the effective address and the writeback value according to the indexing mode.

Three indexing modes are supported. Plain offset mode gives the adjusted address and leaves the base alone. Pre-indexed mode gives the adjusted address and also writes it back to the base. Post-indexed mode uses the untouched base as the address and writes the adjusted value back. All results are registered. The load/store pipeline drives a request for one cycle with `req_valid` and reads the address, writeback value and writeback strobe one clock edge later. Memory access, alignment checks and the register file itself are handled elsewhere.

Top module: `ls_agu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears `out_valid`, `wb_en`, `eff_addr` and `wb_val` to zero on that edge, even if `req_valid` is high.
- R2: In plain offset mode (`amode` = 0), `eff_addr` is base adjusted by the offset, and `wb_en` stays low.
- R3: In pre-indexed mode (`amode` = 1), `eff_addr` and `wb_val` both equal base adjusted by the offset, and `wb_en` is high.
- R4: In post-indexed mode (`amode` = 2), `eff_addr` equals the unmodified base, `wb_val` is base adjusted by the offset, and `wb_en` is high.
- R5: The offset source `ofs_src` selects as follows:
  - 0 selects `imm_val`, zero-extended to 32 bits.
  - 1 selects `index_val` unshifted; `shamt` is ignored.
  - 2 selects `index_val` shifted left by `shamt` (0 to 3). Bits shifted past bit 31 are discarded.
  - 3 behaves like 0.
- R6: With `sub_en` = 1 the offset is subtracted from the base; with `sub_en` = 0 it is added.
- R7: All address arithmetic wraps modulo 2^32 and gives no overflow indication.
- R8: A request sampled with `req_valid` high at a rising edge produces its results, with `out_valid` high, right after that same edge. `out_valid` and `wb_en` are high for exactly one cycle per request, so back-to-back requests give back-to-back results.
- R9: At an edge where `req_valid` is low, `out_valid` and `wb_en` go low, and `eff_addr` and `wb_val` keep their previous values whatever the other inputs do.
- R10: The reserved mode code `amode` = 3 behaves as plain offset mode: adjusted address, no writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm_val | input | 12 | Unsigned immediate offset |
| shamt | input | 2 | Left-shift amount for the shifted-index source |
| ofs_src | input | 2 | Offset source: 0 immediate, 1 index, 2 shifted index, 3 immediate |
| sub_en | input | 1 | 1 subtracts the offset, 0 adds it |
| amode | input | 2 | Indexing mode: 0 offset, 1 pre-indexed, 2 post-indexed, 3 offset |
| out_valid | output | 1 | Results valid this cycle |
| eff_addr | output | 32 | Effective address |
| wb_val | output | 32 | Value to write back to the base register |
| wb_en | output | 1 | Base writeback strobe |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 12-bit immediate and a 2-bit shift amount. The shift amount range is therefore small enough that every value from 0 to 3 is driven on an index with set top bits, which exercises the discarded high bits. Wrap-around is reached by adding to a base near 2^32 and by subtracting from a small base. The full immediate of 0xFFF shows that no sign extension takes place.

// File: rtl/agu_pkg.sv
// Package agu_pkg
// Shared code values for the load/store address generator.
// Assumes two-bit codes on the ports; unused codes are folded onto
// a defined behaviour by the consumers.
package agu_pkg;

    // Where the offset comes from
    typedef enum logic [1:0] {
        OFS_IMM     = 2'd0,
        OFS_IDX     = 2'd1,
        OFS_IDX_SHL = 2'd2,
        OFS_RSVD    = 2'd3
    } agu_ofs_src_e;

    // Which value becomes the address and whether the base is updated
    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } agu_mode_e;

    // True for the modes that update the base register
    function automatic logic mode_writes_back(agu_mode_e m);
        return (m == AM_PRE) || (m == AM_POST);
    endfunction

endpackage

// File: rtl/agu_offset_sel.sv
// Module agu_offset_sel
// Forms the full-width offset from one of three sources: the zero-extended
// immediate, the index register, or the index register shifted left.
// Assumes IMM_W <= DATA_W. Bits shifted beyond the top are dropped.
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 2
) (
    input  agu_ofs_src_e        src,
    input  logic [IMM_W-1:0]    imm,
    input  logic [DATA_W-1:0]   index,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [DATA_W-1:0]   offset
);
    localparam int NUM_SHIFTS = 1 << SHAMT_W;
    localparam int PAD_W      = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] shifted [NUM_SHIFTS];

    // Zero-extend the immediate to the datapath width
    assign imm_ext = {{PAD_W{1'b0}}, imm};

    // One fixed-shift copy of the index per shift amount
    for (genvar k = 0; k < NUM_SHIFTS; k++) begin : g_shift
        assign shifted[k] = index << k;
    end

    // Pick the offset source; the reserved code falls back to the immediate
    always_comb begin
        case (src)
            OFS_IDX:     offset = index;
            OFS_IDX_SHL: offset = shifted[shamt];
            default:     offset = imm_ext;
        endcase
    end

    // A zero shift must return the index unchanged
    always_comb begin
        if (src == OFS_IDX_SHL && shamt == '0)
            AST_SHL_ZERO_IS_INDEX: assert (offset == index); // R5
    end

endmodule

// File: rtl/agu_adder.sv
// Module agu_adder
// Adds the offset to, or subtracts it from, the base value.
// Assumes wrap-around arithmetic; no carry or overflow leaves the module.
module agu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              sub,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] operand;

    // Two's-complement operand: invert for subtraction, carry-in adds the one
    assign operand = sub ? ~offset : offset;

    // Single adder for both directions, truncated to the datapath width
    assign result = base + operand + {{(DATA_W-1){1'b0}}, sub};

    // Undoing the operation must recover the base
    always_comb begin
        AST_ADDER_INVERSE: assert ((sub ? result + offset : result - offset) == base); // R6
    end

endmodule

// File: rtl/agu_mode_mux.sv
// Module agu_mode_mux
// Chooses the effective address, the writeback value and the writeback
// strobe from the indexing mode. Assumes the reserved code acts as plain
// offset mode.
module agu_mode_mux
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  agu_mode_e          mode,
    input  logic [DATA_W-1:0]  base,
    input  logic [DATA_W-1:0]  adjusted,
    output logic [DATA_W-1:0]  addr,
    output logic [DATA_W-1:0]  wb_data,
    output logic               wb_req
);
    // Address is the raw base only for post-indexing
    always_comb begin
        addr    = (mode == AM_POST) ? base : adjusted;
        wb_data = adjusted;
        wb_req  = mode_writes_back(mode);
    end

    // Writeback is requested only by the two updating modes
    always_comb begin
        if (wb_req)
            AST_WB_MODE_ONLY: assert (mode == AM_PRE || mode == AM_POST); // R2
    end

endmodule

// File: rtl/agu_out_reg.sv
// Module agu_out_reg
// Result register stage. Captures address and writeback value on a valid
// request and holds them otherwise; valid and strobe are single-cycle pulses.
// Synchronous active-low reset clears everything.
module agu_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wb_d,
    input  logic              we_d,
    output logic              valid_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] wb_q,
    output logic              we_q
);
    // Pulse outputs follow the request each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            valid_q <= req_valid;
            we_q    <= req_valid & we_d;
        end
    end

    // Data outputs load on a request and hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wb_q   <= '0;
        end else if (req_valid) begin
            addr_q <= addr_d;
            wb_q   <= wb_d;
        end
    end

    AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> valid_q); // R8

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> valid_q); // R8

    AST_IDLE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!valid_q && !we_q)); // R9

    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(addr_q) && $stable(wb_q))); // R9

endmodule

// File: rtl/ls_agu.sv
// Module ls_agu
// Load/store address generator top. Selects the offset, applies it to the
// base, chooses address and writeback by indexing mode, and registers the
// results one edge after a valid request.
// Assumes base and index arrive already read from the register file.
module ls_agu
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [DATA_W-1:0]   base_val,
    input  logic [DATA_W-1:0]   index_val,
    input  logic [IMM_W-1:0]    imm_val,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic [1:0]          ofs_src,
    input  logic                sub_en,
    input  logic [1:0]          amode,
    output logic                out_valid,
    output logic [DATA_W-1:0]   eff_addr,
    output logic [DATA_W-1:0]   wb_val,
    output logic                wb_en
);
    agu_ofs_src_e      src_e;
    agu_mode_e         mode_e;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] adjusted;
    logic [DATA_W-1:0] addr_d;
    logic [DATA_W-1:0] wb_d;
    logic              we_d;

    // Decode the port codes into typed values
    assign src_e  = agu_ofs_src_e'(ofs_src);
    assign mode_e = agu_mode_e'(amode);

    agu_offset_sel #(
        .DATA_W  (DATA_W),
        .IMM_W   (IMM_W),
        .SHAMT_W (SHAMT_W)
    ) i_offset_sel (
        .src    (src_e),
        .imm    (imm_val),
        .index  (index_val),
        .shamt  (shamt),
        .offset (offset)
    );

    agu_adder #(
        .DATA_W (DATA_W)
    ) i_adder (
        .base   (base_val),
        .offset (offset),
        .sub    (sub_en),
        .result (adjusted)
    );

    agu_mode_mux #(
        .DATA_W (DATA_W)
    ) i_mode_mux (
        .mode     (mode_e),
        .base     (base_val),
        .adjusted (adjusted),
        .addr     (addr_d),
        .wb_data  (wb_d),
        .wb_req   (we_d)
    );

    agu_out_reg #(
        .DATA_W (DATA_W)
    ) i_out_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .addr_d    (addr_d),
        .wb_d      (wb_d),
        .we_d      (we_d),
        .valid_q   (out_valid),
        .addr_q    (eff_addr),
        .wb_q      (wb_val),
        .we_q      (wb_en)
    );

    AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && amode == 2'd2) |=> (eff_addr == $past(base_val) && wb_en)); // R4

    AST_PRE_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && amode == 2'd1) |=> (eff_addr == wb_val && wb_en)); // R3

    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (amode == 2'd0 || amode == 2'd3)) |=> (out_valid && !wb_en)); // R10

    AST_ZERO_IMM_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ofs_src == 2'd0 && imm_val == '0) |=> (eff_addr == $past(base_val))); // R7

endmodule

// File: tb/test_ls_agu.sv
// Directed bench for ls_agu: one task per scenario, each checking its results.
module test_ls_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [11:0] imm_val = '0;
    logic [1:0]  shamt = '0;
    logic [1:0]  ofs_src = '0;
    logic        sub_en = 1'b0;
    logic [1:0]  amode = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] wb_val;
    logic        wb_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    ls_agu i_ls_agu (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .base_val  (base_val),
        .index_val (index_val),
        .imm_val   (imm_val),
        .shamt     (shamt),
        .ofs_src   (ofs_src),
        .sub_en    (sub_en),
        .amode     (amode),
        .out_valid (out_valid),
        .eff_addr  (eff_addr),
        .wb_val    (wb_val),
        .wb_en     (wb_en)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%08h, expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Offset per R5
    function automatic logic [31:0] model_ofs(logic [1:0] src, logic [11:0] imm,
                                              logic [31:0] idx, logic [1:0] sh);
        case (src)
            2'd1:    return idx;
            2'd2:    return idx << sh;
            default: return {20'd0, imm};
        endcase
    endfunction

    // Issue one request at a falling edge and check the result after the next rising edge
    task automatic issue(string req, logic [31:0] b, logic [31:0] idx, logic [11:0] imm,
                         logic [1:0] sh, logic [1:0] src, logic sub, logic [1:0] md);
        logic [31:0] ofs, adj, exp_addr;
        logic        exp_we;
        base_val = b; index_val = idx; imm_val = imm; shamt = sh;
        ofs_src = src; sub_en = sub; amode = md; req_valid = 1'b1;
        ofs = model_ofs(src, imm, idx, sh);
        adj = sub ? b - ofs : b + ofs;
        exp_addr = (md == 2'd2) ? b : adj;
        exp_we = (md == 2'd1) || (md == 2'd2);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
        chk(req, "eff_addr", eff_addr, exp_addr);
        chk(req, "wb_val", wb_val, adj);
        chk(req, "wb_en", {31'd0, wb_en}, {31'd0, exp_we});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        req_valid = 1'b1; base_val = 32'h1234_5678; amode = 2'd1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1", "eff_addr", eff_addr, 32'd0);
        chk("R1", "wb_val", wb_val, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_offset_mode;
        issue("R2", 32'h2000_0000, 32'h0, 12'h005, 2'd0, 2'd0, 1'b0, 2'd0);
        issue("R2", 32'h2000_0100, 32'h40, 12'h0, 2'd0, 2'd1, 1'b1, 2'd0);
    endtask

    task automatic t_pre_mode;
        issue("R3", 32'h2000_0800, 32'h0, 12'h010, 2'd0, 2'd0, 1'b0, 2'd1);
        issue("R3", 32'h1000_0000, 32'h8, 12'h0, 2'd2, 2'd2, 1'b1, 2'd1);
    endtask

    task automatic t_post_mode;
        issue("R4", 32'h3000_0000, 32'h0, 12'h004, 2'd0, 2'd0, 1'b0, 2'd2);
        issue("R4", 32'h3000_0040, 32'h10, 12'h0, 2'd1, 2'd2, 1'b1, 2'd2);
    endtask

    task automatic t_sources;
        // full immediate must zero-extend
        issue("R5", 32'h0000_1000, 32'hDEAD_BEEF, 12'hFFF, 2'd3, 2'd0, 1'b0, 2'd0);
        // plain index ignores shamt
        issue("R5", 32'h0, 32'h0000_0011, 12'h7, 2'd3, 2'd1, 1'b0, 2'd0);
        // every shift amount, top bits lost
        for (int s = 0; s < 4; s++)
            issue("R5", 32'h100, 32'hC000_0003, 12'h0, s[1:0], 2'd2, 1'b0, 2'd1);
        // reserved source acts as immediate
        issue("R5", 32'h500, 32'hFFFF_FFFF, 12'h123, 2'd1, 2'd3, 1'b0, 2'd0);
    endtask

    task automatic t_direction;
        issue("R6", 32'h0000_8000, 32'h0, 12'h100, 2'd0, 2'd0, 1'b1, 2'd1);
        issue("R6", 32'h0000_8000, 32'h0, 12'h100, 2'd0, 2'd0, 1'b0, 2'd1);
    endtask

    task automatic t_wrap;
        issue("R7", 32'hFFFF_FFF0, 32'h0, 12'h020, 2'd0, 2'd0, 1'b0, 2'd1);
        issue("R7", 32'h0000_0004, 32'h10, 12'h0, 2'd0, 2'd1, 1'b1, 2'd2);
    endtask

    task automatic t_back_to_back;
        // two consecutive requests, then valid must drop
        base_val = 32'h4000; index_val = 32'h0; imm_val = 12'h8; shamt = 2'd0;
        ofs_src = 2'd0; sub_en = 1'b0; amode = 2'd1; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "first eff_addr", eff_addr, 32'h4008);
        chk("R8", "first wb_en", {31'd0, wb_en}, 32'd1);
        amode = 2'd0; imm_val = 12'h10;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "second eff_addr", eff_addr, 32'h4010);
        chk("R8", "second out_valid", {31'd0, out_valid}, 32'd1);
        chk("R8", "second wb_en", {31'd0, wb_en}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "valid drops", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_idle;
        issue("R9", 32'h5000, 32'h0, 12'h4, 2'd0, 2'd0, 1'b0, 2'd2);
        base_val = 32'hAAAA_0000; imm_val = 12'h777; amode = 2'd1; req_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9", "wb_en", {31'd0, wb_en}, 32'd0);
        chk("R9", "eff_addr held", eff_addr, 32'h5000);
        chk("R9", "wb_val held", wb_val, 32'h5004);
    endtask

    task automatic t_reserved_mode;
        issue("R10", 32'h6000, 32'h3, 12'h0, 2'd2, 2'd2, 1'b0, 2'd3);
    endtask

    task automatic t_reset_mid;
        // a request during reset must not reach the outputs
        issue("R1", 32'h7000, 32'h0, 12'h1, 2'd0, 2'd0, 1'b0, 2'd1);
        t_reset;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_offset_mode;
        t_pre_mode;
        t_post_mode;
        t_sources;
        t_direction;
        t_wrap;
        t_back_to_back;
        t_idle;
        t_reserved_mode;
        t_reset_mid;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule